// File: doc/BRIEF.md
# Adder-Subtractor with Condition Flags and Branch Evaluator

This block is the arithmetic slice of a small processor datapath. It adds or subtracts two signed two's complement operands of a configurable width. It can also run a flag-only compare, which subtracts, or a flag-only test, which takes a bitwise AND. Subtraction uses the same adder as addition: the second operand is inverted and the carry input is forced to one.

Each operation produces four condition bits: negative, zero, overflow and carry. They are loaded into a four-bit flag register on the clock edge when the update enable is high. A combinational evaluator reads the registered flags and decides, for one of eight branch conditions, whether a conditional branch is taken. Compare and test change only the flags. They mark their result as not writable so that the register file does not store it.

There is no sequential control beyond the flag register. Each operation takes one cycle and its flags are visible the cycle after it is issued.

Top module: `alu_ccr`

## Requirements
- R1: With `op_sel`=00 (add), `result` equals `opnd_a + opnd_b` modulo 2^W in the same cycle.
- R2: With `op_sel`=01 (subtract), `result` equals `opnd_a - opnd_b` modulo 2^W, formed as A + ~B + 1; for W=8, F0h minus 14h gives DCh.
- R3: After an update, `flags[3]` (N) equals the most significant bit of the result of the operation that was captured.
- R4: After an update, `flags[2]` (Z) is 1 exactly when every bit of that result was 0.
- R5: After an arithmetic update, `flags[0]` (C) equals the carry out of the most significant bit. For subtract and compare, a set C means no borrow occurred.
- R6: After an arithmetic update, `flags[1]` (V) equals the carry into the most significant bit XOR the carry out of it. Examples: 7Fh+01h sets V, and 80h+FFh sets both V and C.
- R7: With `op_sel`=10 (compare), the flags are computed from A−B. With `op_sel`=10 or 11, `wb_ok` is 0; it is 1 for add and subtract.
- R8: With `op_sel`=11 (test), `result` is A AND B, N and Z follow that value, and V and C are loaded as 0.
- R9: When `flag_we` is 0, `flags` keep their value across the clock edge, whatever the operation.
- R10: While `rst_n` is low, `flags` are 0000.
- R11: `br_taken` follows `cond_sel`: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=0, 5 N=1, 6 V=1, 7 V=0.
- R12: `br_taken` is combinational from the registered flags, so a change of `cond_sel` is reflected within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| op_sel | input | 2 | 00 add, 01 subtract, 10 compare, 11 test |
| flag_we | input | 1 | Load flags on this clock edge |
| cond_sel | input | 3 | Branch condition code |
| result | output | W | Sum, difference or AND value |
| wb_ok | output | 1 | Result may be written back |
| flags | output | 4 | Registered {N, Z, V, C} |
| br_taken | output | 1 | Selected branch condition holds |

## Verification
The bench targets the cases where a design is most likely to go wrong:
- Signed overflow in both directions. A design that takes V from the carry out alone would flag 80h+FFh correctly but miss 7Fh+01h.
- A subtraction with an equal operand pair. A design without the forced carry-in would give FFh, not zero with C set.
- A compare whose difference overflows.
- A test that must clear V and C left set by a previous add. Stale carry logic would keep them set.
- A disabled update that must leave the flags alone.

All eight branch codes are swept after every vector. This catches a swapped or inverted condition.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_CMP = 2'b10,
        OP_TST = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        CC_ZS = 3'd0,
        CC_ZC = 3'd1,
        CC_CS = 3'd2,
        CC_CC = 3'd3,
        CC_PL = 3'd4,
        CC_MI = 3'd5,
        CC_VS = 3'd6,
        CC_VC = 3'd7
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         c_msb_in
);
    logic [W-1:0] b_eff;

    assign b_eff = sub ? ~b : b;

    generate
        if (W == 1) begin : g_single
            assign c_msb_in   = sub;
            assign {c_out, sum} = {1'b0, a} + {1'b0, b_eff} + {1'b0, sub};
        end else begin : g_split
            localparam int LW = W - 1;
            logic [LW-1:0] low_sum;
            logic          top_sum;
            // carry into the msb comes out of the lower slice
            assign {c_msb_in, low_sum} = {1'b0, a[LW-1:0]} + {1'b0, b_eff[LW-1:0]}
                                         + {{LW{1'b0}}, sub};
            assign {c_out, top_sum} = {1'b0, a[W-1]} + {1'b0, b_eff[W-1]}
                                      + {1'b0, c_msb_in};
            assign sum = {top_sum, low_sum};
        end
    endgenerate
endmodule

// File: rtl/flag_gen.sv
module flag_gen
    import alu_ccr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] res,
    input  logic         is_logic,
    input  logic         c_out,
    input  logic         c_msb_in,
    output ccr_t         nxt
);
    always_comb begin
        nxt.n = res[W-1];
        nxt.z = (res == '0);
        if (is_logic) begin
            nxt.v = 1'b0;
            nxt.c = 1'b0;
        end else begin
            nxt.v = c_out ^ c_msb_in;
            nxt.c = c_out;
        end
    end
endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import alu_ccr_pkg::*;
(
    input  ccr_t  cur,
    input  cond_e cond,
    output logic  taken
);
    always_comb begin
        unique case (cond)
            CC_ZS: taken =  cur.z;
            CC_ZC: taken = ~cur.z;
            CC_CS: taken =  cur.c;
            CC_CC: taken = ~cur.c;
            CC_PL: taken = ~cur.n;
            CC_MI: taken =  cur.n;
            CC_VS: taken =  cur.v;
            CC_VC: taken = ~cur.v;
        endcase
    end
endmodule

// File: rtl/alu_ccr.sv
module alu_ccr
    import alu_ccr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [1:0]   op_sel,
    input  logic         flag_we,
    input  logic [2:0]   cond_sel,
    output logic [W-1:0] result,
    output logic         wb_ok,
    output logic [3:0]   flags,
    output logic         br_taken
);
    op_e          op;
    logic         do_sub;
    logic [W-1:0] arith_sum;
    logic         c_out;
    logic         c_msb_in;
    ccr_t         ccr_nxt;
    ccr_t         ccr_q;

    assign op     = op_e'(op_sel);
    assign do_sub = (op == OP_SUB) || (op == OP_CMP);

    addsub_core #(.W(W)) u_add (
        .a        (opnd_a),
        .b        (opnd_b),
        .sub      (do_sub),
        .sum      (arith_sum),
        .c_out    (c_out),
        .c_msb_in (c_msb_in)
    );

    always_comb begin
        unique case (op)
            OP_ADD: begin result = arith_sum;       wb_ok = 1'b1; end
            OP_SUB: begin result = arith_sum;       wb_ok = 1'b1; end
            OP_CMP: begin result = arith_sum;       wb_ok = 1'b0; end
            OP_TST: begin result = opnd_a & opnd_b; wb_ok = 1'b0; end
        endcase
    end

    flag_gen #(.W(W)) u_flags (
        .res      (result),
        .is_logic (op == OP_TST),
        .c_out    (c_out),
        .c_msb_in (c_msb_in),
        .nxt      (ccr_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ccr_q <= '0;
        else if (flag_we)
            ccr_q <= ccr_nxt;
    end

    assign flags = ccr_q;

    branch_eval u_br (
        .cur   (ccr_q),
        .cond  (cond_e'(cond_sel)),
        .taken (br_taken)
    );
endmodule

// File: rtl/alu_ccr_chk.sv
module alu_ccr_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] result,
    input logic [1:0]   op_sel,
    input logic         flag_we,
    input logic [2:0]   cond_sel,
    input logic [3:0]   flags,
    input logic         wb_ok,
    input logic         br_taken
);
    // R3
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> flags[3] == $past(result[W-1]));

    // R4
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> flags[2] == ($past(result) == '0));

    // R7
    no_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel[1] |-> !wb_ok);

    // R8
    test_clears_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel == 2'b11) |=> flags[1:0] == 2'b00);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags));

    // R10
    reset_flags_chk: assert property (@(posedge clk)
        !rst_n |-> flags == 4'b0000);

    // R11
    branch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 3'd0) |-> br_taken == flags[2]);

    // R11
    branch_minus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 3'd5) |-> br_taken == flags[3]);
endmodule

bind alu_ccr alu_ccr_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .result   (result),
    .op_sel   (op_sel),
    .flag_we  (flag_we),
    .cond_sel (cond_sel),
    .flags    (flags),
    .wb_ok    (wb_ok),
    .br_taken (br_taken)
);

// File: tb/tb_alu_ccr.sv
module tb_alu_ccr;
    localparam int W = 8;
    localparam int NV = 11;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] opnd_a, opnd_b;
    logic [1:0]   op_sel;
    logic         flag_we;
    logic [2:0]   cond_sel;
    logic [W-1:0] result;
    logic         wb_ok;
    logic [3:0]   flags;
    logic         br_taken;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    alu_ccr #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_sel(op_sel), .flag_we(flag_we), .cond_sel(cond_sel),
        .result(result), .wb_ok(wb_ok), .flags(flags), .br_taken(br_taken)
    );

    // {op, a, b, expected result, expected {N,Z,V,C}}
    localparam logic [29:0] VEC [NV] = '{
        {2'b00, 8'h02, 8'h03, 8'h05, 4'b0000},
        {2'b01, 8'hF0, 8'h14, 8'hDC, 4'b1001},
        {2'b00, 8'h7F, 8'h01, 8'h80, 4'b1010},
        {2'b00, 8'h80, 8'hFF, 8'h7F, 4'b0011},
        {2'b00, 8'hFF, 8'h01, 8'h00, 4'b0101},
        {2'b01, 8'h05, 8'h05, 8'h00, 4'b0101},
        {2'b01, 8'h03, 8'h05, 8'hFE, 4'b1000},
        {2'b10, 8'h80, 8'h01, 8'h7F, 4'b0011},
        {2'b11, 8'hF0, 8'h0F, 8'h00, 4'b0100},
        {2'b11, 8'h88, 8'h80, 8'h80, 4'b1000},
        {2'b01, 8'h7F, 8'hFF, 8'h80, 4'b1010}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_branch(input logic [3:0] f, input int c);
        case (c)
            0: return f[2];
            1: return ~f[2];
            2: return f[0];
            3: return ~f[0];
            4: return ~f[3];
            5: return f[3];
            6: return f[1];
            default: return ~f[1];
        endcase
    endfunction

    // sweep all eight codes against expected flags (R11, R12)
    task automatic sweep_branch(input logic [3:0] f);
        for (int c = 0; c < 8; c++) begin
            cond_sel = 3'(c);
            #0.5;
            chk("R11 branch", {31'd0, br_taken}, {31'd0, exp_branch(f, c)});
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] held;
        rst_n = 1'b0; opnd_a = '0; opnd_b = '0; op_sel = 2'b00;
        flag_we = 1'b0; cond_sel = 3'd0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset flags", {28'd0, flags}, 32'h0);
        cond_sel = 3'd1; #0.5;
        chk("R12 branch nonzero after reset", {31'd0, br_taken}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [7:0] va, vb, er;
            logic [3:0] ef;
            string tg;
            {op, va, vb, er, ef} = VEC[i];
            tg = (op == 2'b00) ? "R1" : (op == 2'b01) ? "R2" : (op == 2'b10) ? "R7" : "R8";
            @(negedge clk);
            op_sel = op; opnd_a = va; opnd_b = vb; flag_we = 1'b1;
            #1;
            chk({tg, " result"}, {24'd0, result}, {24'd0, er});
            chk("R7 wb_ok", {31'd0, wb_ok}, {31'd0, ~op[1]});
            @(posedge clk);
            #1;
            flag_we = 1'b0;
            chk("R3 N", {31'd0, flags[3]}, {31'd0, ef[3]});
            chk("R4 Z", {31'd0, flags[2]}, {31'd0, ef[2]});
            chk("R6 V", {31'd0, flags[1]}, {31'd0, ef[1]});
            chk("R5 C", {31'd0, flags[0]}, {31'd0, ef[0]});
            sweep_branch(ef);
        end

        // R9: disabled update keeps flags from an add that would set Z and C
        held = flags;
        @(negedge clk);
        op_sel = 2'b00; opnd_a = 8'hFF; opnd_b = 8'h01; flag_we = 1'b0;
        @(posedge clk); #1;
        chk("R9 hold", {28'd0, flags}, {28'd0, held});

        // R8: test after an add that set V and C loads V=C=0
        @(negedge clk);
        op_sel = 2'b00; opnd_a = 8'h80; opnd_b = 8'hFF; flag_we = 1'b1;
        @(negedge clk);
        op_sel = 2'b11; opnd_a = 8'h01; opnd_b = 8'h01;
        @(posedge clk); #1;
        flag_we = 1'b0;
        chk("R8 test flags", {28'd0, flags}, 32'h0);

        // R10: reset in mid-run clears set flags
        @(negedge clk);
        op_sel = 2'b00; opnd_a = 8'h7F; opnd_b = 8'h01; flag_we = 1'b1;
        @(negedge clk);
        flag_we = 1'b0;
        rst_n = 1'b0; #1;
        chk("R10 mid-run reset", {28'd0, flags}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule